// File: doc/BRIEF.md
# ADC Convert-Start and Power-Mode Sequencer

This block holds the digital timing and control around an 8-bit successive-approximation converter. One asynchronous start line drives it. The block resynchronizes that line onto the system clock and uses it for three things:

- it switches converter power on,
- it fixes the instant the sample is frozen,
- it decides whether power is kept or dropped once a conversion finishes.

A rising start edge fires a fixed-length internal power-up pulse. The block ORs this pulse with the start level and launches the conversion on the falling edge of that combined signal. The falling edge therefore comes from whichever of the two ends later.

The bit-trial engine sits outside the block. When a conversion begins, the block gives it a one-cycle launch pulse. The engine answers with a done strobe and the 8-bit code. On done, the block latches the code into a held output register, releases the sampler back to tracking and clears busy. It then samples the start line. If the line is high, power stays on (continuous mode). If it is low, power is removed until the next rising edge (power-down mode). The last code stays readable while power is off.

Top module: `adc_start_seq`

## Requirements
- R1: While reset is asserted and right after it, power enable is 0, busy is 0, the hold control is 0 (tracking), the result register is 0x00 and the mode output is 0 (power-down mode).
- R2: A start rising edge accepted while idle raises power enable on the third rising clock edge after the start line goes high.
- R3: Let the start line rise before clock edge 1 and fall before edge H+1, with a power-up length of P cycles. Busy then rises on edge max(P+4, H+3). If power is already on and no pulse is running, busy rises on edge 3 after the start line falls. A one-cycle launch pulse coincides with busy rising.
- R4: The hold control is 1 exactly while busy is 1 and 0 (tracking) otherwise.
- R5: A done strobe while busy clears busy on the same clock edge and loads the result bus into the result register.
- R6: If the synchronized start line is high when busy falls, the mode output becomes 1 (continuous) and power enable stays 1.
- R7: If the synchronized start line is low when busy falls, the mode output becomes 0 and power enable drops to 0.
- R8: A done strobe while not busy has no effect: busy stays 0 and the result register keeps its value.
- R9: Start edges while busy start no conversion and no power-up pulse, so one start pulse yields exactly one busy period.
- R10: A second rising edge while the power-up pulse is still running does not restart it, so the launch stays at edge P+4.
- R11: While power is off, the result register keeps the last code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_async_i | input | 1 | Asynchronous convert-start line |
| conv_done_i | input | 1 | End-of-conversion strobe from the bit-trial engine |
| conv_result_i | input | 8 | Conversion code from the bit-trial engine |
| pwr_en_o | output | 1 | Converter power enable |
| hold_o | output | 1 | Sampler control, 1 = hold, 0 = track |
| conv_start_o | output | 1 | One-cycle launch pulse to the bit-trial engine |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 8 | Held conversion result |
| mode_cont_o | output | 1 | 1 = continuous mode, 0 = power-down mode |

## Verification
The launch has two paths. Through the power-up pulse it is due P+4 edges after the start line rises. Through a late start release it is due H+3 edges, counting the two synchronizer flops, the edge-detect flop and the busy register. The bench counts edges from the negative edge at which it drives the line and compares the count with the larger of the two. Done is registered with no pipeline, so busy, the result, the mode and power enable are all sampled at the first negative edge after the strobed rising edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    MODE_PWRDN = 1'b0,
    MODE_CONT  = 1'b1
  } run_mode_e;

  // Clock cycles covering a duration, rounded up.
  function automatic int unsigned cycles_for_ns(input int unsigned ns,
                                                input int unsigned clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  // Edge on which busy rises after the start line goes high (edge 1 first).
  function automatic int unsigned launch_edge(input int unsigned pwrup,
                                              input int unsigned hi_cycles);
    int unsigned a;
    int unsigned b;
    a = pwrup + 4;
    b = hi_cycles + 3;
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level_o;
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~last_q;
  assign fall_o  = ~level_o & last_q;

endmodule

// File: rtl/adc_seq_oneshot.sv
module adc_seq_oneshot #(
  parameter int unsigned LEN = 188
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic inhibit_i,
  output logic active_o,
  output logic fired_o
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  assign fired_o  = trig_i & ~inhibit_i & ~active_o;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (fired_o)  cnt_q <= CW'(LEN);
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_level_i,
  input  logic              ext_rise_i,
  input  logic              pulse_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              pwr_en_o,
  output logic              hold_o,
  output logic              start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output run_mode_e         mode_o,
  output logic              gated_fall_o,
  output logic              launch_o,
  output logic              finish_o
);

  logic gated;
  logic gated_q;

  assign gated        = ext_level_i | pulse_i;
  assign gated_fall_o = gated_q & ~gated;
  assign launch_o     = gated_fall_o & ~busy_o & pwr_en_o;
  assign finish_o     = done_i & busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gated;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      hold_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= launch_o;
      if (finish_o) begin
        busy_o <= 1'b0;
        hold_o <= 1'b0;
      end else if (launch_o) begin
        busy_o <= 1'b1;
        hold_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_en_o <= 1'b0;
      mode_o   <= MODE_PWRDN;
      data_o   <= '0;
    end else if (finish_o) begin
      data_o   <= result_i;
      mode_o   <= ext_level_i ? MODE_CONT : MODE_PWRDN;
      pwr_en_o <= ext_level_i;
    end else if (ext_rise_i && !busy_o) begin
      pwr_en_o <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter int unsigned PWRUP_CYCLES = cycles_for_ns(1500, 125)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_async_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_result_i,
  output logic              pwr_en_o,
  output logic              hold_o,
  output logic              conv_start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mode_cont_o
);

  logic      ext_level;
  logic      ext_rise;
  logic      ext_fall;
  logic      pulse_active;
  logic      pulse_fired;
  logic      gated_fall;
  logic      launch;
  logic      finish;
  run_mode_e mode;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (start_async_i),
    .level_o (ext_level),
    .rise_o  (ext_rise),
    .fall_o  (ext_fall)
  );

  adc_seq_oneshot #(.LEN(PWRUP_CYCLES)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (ext_rise),
    .inhibit_i (busy_o),
    .active_o  (pulse_active),
    .fired_o   (pulse_fired)
  );

  adc_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_level_i  (ext_level),
    .ext_rise_i   (ext_rise),
    .pulse_i      (pulse_active),
    .done_i       (conv_done_i),
    .result_i     (conv_result_i),
    .pwr_en_o     (pwr_en_o),
    .hold_o       (hold_o),
    .start_o      (conv_start_o),
    .busy_o       (busy_o),
    .data_o       (data_o),
    .mode_o       (mode),
    .gated_fall_o (gated_fall),
    .launch_o     (launch),
    .finish_o     (finish)
  );

  assign mode_cont_o = (mode == MODE_CONT);

endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              hold_o,
  input logic              conv_start_o,
  input logic              pwr_en_o,
  input logic              mode_cont_o,
  input logic [DATA_W-1:0] data_o,
  input logic              conv_done_i,
  input logic              launch,
  input logic              pulse_fired
);

  assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> conv_start_o);

  assert_launch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_o);

  assert_hold_tracks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o == busy_o);

  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && conv_done_i) |=> !busy_o);

  assert_mode_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (pwr_en_o == mode_cont_o));

  assert_busy_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pwr_en_o);

  assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(data_o));

  assert_no_pulse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pulse_fired);

endmodule

bind adc_start_seq adc_start_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .hold_o       (hold_o),
  .conv_start_o (conv_start_o),
  .pwr_en_o     (pwr_en_o),
  .mode_cont_o  (mode_cont_o),
  .data_o       (data_o),
  .conv_done_i  (conv_done_i),
  .launch       (launch),
  .pulse_fired  (pulse_fired)
);

// File: tb/test_adc_start_seq.sv
module test_adc_start_seq;

  localparam int P = 12;
  localparam int NV = 6;

  // {hold-high cycles, result code, start high again during busy}
  localparam logic [16:0] VEC [NV] = '{
    {8'd1,  8'h5A, 1'b0},
    {8'd30, 8'hFF, 1'b1},
    {8'd0,  8'h00, 1'b1},
    {8'd0,  8'h81, 1'b0},
    {8'd14, 8'hC3, 1'b0},
    {8'd12, 8'h3C, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_async_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic [7:0] conv_result_i = 8'h00;
  logic       pwr_en_o;
  logic       hold_o;
  logic       conv_start_o;
  logic       busy_o;
  logic [7:0] data_o;
  logic       mode_cont_o;

  int checks = 0;
  int fails = 0;
  int busy_rises = 0;
  int convs = 0;
  logic busy_prev = 1'b0;
  logic ext_now = 1'b0;

  always #4 clk = ~clk;

  adc_start_seq #(.PWRUP_CYCLES(P)) i_adc_start_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_async_i (start_async_i),
    .conv_done_i   (conv_done_i),
    .conv_result_i (conv_result_i),
    .pwr_en_o      (pwr_en_o),
    .hold_o        (hold_o),
    .conv_start_o  (conv_start_o),
    .busy_o        (busy_o),
    .data_o        (data_o),
    .mode_cont_o   (mode_cont_o)
  );

  always @(negedge clk) begin
    if (busy_o && !busy_prev) busy_rises++;
    busy_prev <= busy_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Waits for busy; drops the start line after hi cycles (or at once if it is already high).
  task automatic run_launch(input int hi, input int expect_edges, input bit pwr_chk, output int seen);
    int n = 0;
    seen = -1;
    if (ext_now) begin
      start_async_i = 1'b0;
      ext_now = 1'b0;
    end else begin
      start_async_i = 1'b1;
      ext_now = 1'b1;
    end
    while (n < 400 && seen < 0) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pwr_chk && n == 2) chk("R2 power before third edge", pwr_en_o, 0);
      if (pwr_chk && n == 3) chk("R2 power on third edge", pwr_en_o, 1);
      if (busy_o) seen = n;
      if (ext_now && n == hi) begin
        start_async_i = 1'b0;
        ext_now = 1'b0;
      end
    end
    chk("R3 launch edge", seen, expect_edges);
    chk("R3 launch pulse with busy", conv_start_o, 1);
    chk("R4 hold during busy", hold_o, 1);
  endtask

  task automatic finish_conv(input logic [7:0] code, input bit relaunch);
    repeat (5) @(negedge clk);
    if (relaunch) begin
      start_async_i = 1'b1;
      ext_now = 1'b1;
    end
    repeat (5) @(negedge clk);
    chk("R3 launch pulse single cycle", conv_start_o, 0);
    conv_result_i = code;
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    conv_result_i = ~code;
    convs++;
    chk("R5 busy cleared", busy_o, 0);
    chk("R4 tracking after end", hold_o, 0);
    chk("R5 result latched", data_o, code);
    if (relaunch) begin
      chk("R6 continuous mode", mode_cont_o, 1);
      chk("R6 power kept", pwr_en_o, 1);
    end else begin
      chk("R7 power-down mode", mode_cont_o, 0);
      chk("R7 power removed", pwr_en_o, 0);
    end
    repeat (20) @(negedge clk);
    chk("R9 no second conversion", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    report();
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk("R1 power in reset", pwr_en_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 power", pwr_en_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 tracking", hold_o, 0);
    chk("R1 result", data_o, 0);
    chk("R1 mode", mode_cont_o, 0);

    // R8: done strobe while idle
    conv_result_i = 8'hEE;
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    @(negedge clk);
    chk("R8 idle done busy", busy_o, 0);
    chk("R8 idle done result", data_o, 0);

    for (int i = 0; i < NV; i++) begin
      int hi;
      int exp_e;
      bit from_cont;
      hi = int'(VEC[i][16:9]);
      from_cont = ext_now;
      exp_e = from_cont ? 3 : ((P + 4 > hi + 3) ? P + 4 : hi + 3);
      run_launch(hi, exp_e, !from_cont, seen);
      finish_conv(VEC[i][8:1], VEC[i][0]);
    end

    // R11: value held while powered down
    repeat (30) @(negedge clk);
    chk("R11 powered down", pwr_en_o, 0);
    chk("R11 result kept", data_o, 8'h3C);

    // R10: retrigger of the power-up pulse
    begin
      int n = 0;
      seen = -1;
      start_async_i = 1'b1;
      while (n < 400 && seen < 0) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (n == 2) start_async_i = 1'b0;
        if (n == 4) start_async_i = 1'b1;
        if (n == 6) start_async_i = 1'b0;
        if (busy_o) seen = n;
      end
      chk("R10 retrigger ignored", seen, P + 4);
      ext_now = 1'b0;
    end
    finish_conv(8'h99, 1'b0);

    chk("R9 one busy per start", busy_rises, convs);
    report();
  end

endmodule